// File: doc/BRIEF.md
# Spike-Count Serial Binary Adder

This block adds two unsigned binary numbers bit-serially, least significant bit first. Each bit is carried as a polarity: a spike means 1 and an anti-spike means 0. For every operand, a relay stage turns the bit into a number of spikes, two for a 1 and one for a 0. The contributions of both relays are added in an accumulator neuron, which may also hold one leftover spike from the previous position. The accumulator then fires one rule chosen by its total count. That rule emits the sum digit and, in the same step, decides whether one spike stays behind as the carry.

A word ends with the operand-end marker on its final bit pair. The cycle that follows is reserved for a flush step. If a carry spike is still held, the flush emits it as an extra 1 digit and the accumulator is left empty. A new word may start in the cycle after that. Beats with only one operand present, and pairs that fall into the reserved flush cycle, are reported on a one-cycle error pulse and are otherwise dropped.

Top module: `serial_spike_adder`

## Requirements
- R1: A synchronous active-high reset clears the pipeline and the held carry spike. While reset is applied and after it is released, `sum_valid` and `proto_err` are 0, and the first pair after reset sees no carry.
- R2: A valid pair requires `a_valid` and `b_valid` both high in the same cycle. Each relay contributes 2 spikes for a 1 and 1 spike for a 0, so the accumulator count for a pair is 2 + (number of 1 bits) + carry, always within 2..5.
- R3: A count of 5 emits a spike (sum 1) and keeps one carry spike. A count of 4 emits an anti-spike (sum 0) and keeps one carry spike.
- R4: A count of 3 emits a spike (sum 1) and a count of 2 emits an anti-spike (sum 0). Both leave no carry.
- R5: The cycle after a pair marked with `last` is a flush step. If a carry spike is held (count 1), a spike digit is emitted and the carry is cleared. If no carry is held, no digit is emitted.
- R6: A digit appears on `sum_valid`/`sum_bit` directly after the third rising edge, counting the edge that samples its input pair (or that starts its flush step).
- R7: A cycle with exactly one of `a_valid`, `b_valid` high raises `proto_err` for one cycle after that edge. The beat produces no digit and leaves the held carry unchanged.
- R8: A valid pair presented in the cycle right after a `last` pair raises `proto_err` and is dropped. The flush step still takes place.
- R9: On the output, `sum_bit` = 1 encodes a spike and 0 encodes an anti-spike. `sum_valid` is high only in cycles that carry a digit, so a word yields its bit count of digits plus one when a final carry is flushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Operand A bit present this cycle |
| a_bit | input | 1 | Operand A bit (1 spike, 0 anti-spike) |
| b_valid | input | 1 | Operand B bit present this cycle |
| b_bit | input | 1 | Operand B bit (1 spike, 0 anti-spike) |
| last | input | 1 | Marks the final bit pair of a word; requests the flush step |
| sum_valid | output | 1 | A sum digit is present |
| sum_bit | output | 1 | Sum digit (1 spike, 0 anti-spike) |
| proto_err | output | 1 | One-cycle pulse for a dropped beat |

## Verification
The count-range and carry assertions assume that only accepted pairs and flush steps reach the accumulator. They also assume that a flush slot never carries relay spikes, which holds only because the input guard blanks both relays during that slot. The stimulus keeps one idle cycle after each `last` pair in the normal vectors. Single-operand beats and pairs placed inside the flush slot are used only in the directed error tests, where the expected digit stream leaves them out.

// File: rtl/spk_pkg.sv
`timescale 1ns/1ps
package spk_pkg;

    // number of operand relays feeding the accumulator
    localparam int unsigned N_OPS      = 2;
    // spikes a relay delivers for a 1 and for a 0
    localparam int unsigned RELAY_ONE  = 2;
    localparam int unsigned RELAY_ZERO = 1;
    // count of an all-zero pair without carry
    localparam int unsigned CNT_BASE   = N_OPS * RELAY_ZERO;
    localparam int unsigned CNT_MAX    = N_OPS * RELAY_ONE + 1;
    localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        TK_IDLE  = 2'd0,
        TK_PAIR  = 2'd1,
        TK_FLUSH = 2'd2
    } tok_e;

    typedef enum logic {
        POL_ANTI  = 1'b0,
        POL_SPIKE = 1'b1
    } pol_e;

    typedef struct packed {
        logic fire;
        pol_e pol;
        logic carry;
    } fire_t;

    function automatic cnt_t relay_spikes(input logic live, input logic bitv);
        if (!live)
            return '0;
        return bitv ? cnt_t'(RELAY_ONE) : cnt_t'(RELAY_ZERO);
    endfunction

    // rule chosen by the accumulator from its total spike count
    function automatic fire_t pick_rule(input tok_e kind, input cnt_t cnt);
        fire_t r;
        r = '{fire: 1'b0, pol: POL_ANTI, carry: 1'b0};
        if (kind == TK_PAIR) begin
            if (cnt == cnt_t'(CNT_BASE + 3))
                r = '{fire: 1'b1, pol: POL_SPIKE, carry: 1'b1};
            else if (cnt == cnt_t'(CNT_BASE + 2))
                r = '{fire: 1'b1, pol: POL_ANTI,  carry: 1'b1};
            else if (cnt == cnt_t'(CNT_BASE + 1))
                r = '{fire: 1'b1, pol: POL_SPIKE, carry: 1'b0};
            else if (cnt == cnt_t'(CNT_BASE))
                r = '{fire: 1'b1, pol: POL_ANTI,  carry: 1'b0};
        end else if (kind == TK_FLUSH) begin
            if (cnt == cnt_t'(1))
                r = '{fire: 1'b1, pol: POL_SPIKE, carry: 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/spk_guard.sv
`timescale 1ns/1ps
module spk_guard
    import spk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             a_valid,
    input  logic             a_bit,
    input  logic             b_valid,
    input  logic             b_bit,
    input  logic             last,
    output tok_e             tok,
    output logic [N_OPS-1:0] op_live,
    output logic [N_OPS-1:0] op_bits,
    output logic             proto_err
);

    logic pair_in;
    logic lone;
    logic flush_pend_q;
    logic err_q;

    assign pair_in = a_valid & b_valid;
    assign lone    = a_valid ^ b_valid;

    always_comb begin
        if (flush_pend_q)
            tok = TK_FLUSH;
        else if (pair_in)
            tok = TK_PAIR;
        else
            tok = TK_IDLE;
        op_live = (tok == TK_PAIR) ? '1 : '0;
        op_bits = (tok == TK_PAIR) ? {b_bit, a_bit} : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_pend_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            flush_pend_q <= pair_in & ~flush_pend_q & last;
            err_q        <= lone | (pair_in & flush_pend_q);
        end
    end

    assign proto_err = err_q;

    assert_lone_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        lone |-> (tok != TK_PAIR) && (op_live == '0));

    assert_flush_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (tok == TK_PAIR && last) |=> (tok == TK_FLUSH));

    assert_gap_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (tok == TK_FLUSH && a_valid && b_valid) |=> proto_err);

endmodule

// File: rtl/spk_relay.sv
`timescale 1ns/1ps
module spk_relay
    import spk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic bitv,
    output cnt_t spikes
);

    logic live_q;
    logic bit_q;
    cnt_t spikes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= 1'b0;
            bit_q    <= 1'b0;
            spikes_q <= '0;
        end else begin
            live_q   <= live;
            bit_q    <= bitv;
            spikes_q <= relay_spikes(live_q, bit_q);
        end
    end

    assign spikes = spikes_q;

    assert_relay_range_R2: assert property (@(posedge clk) disable iff (rst)
        live_q |=> (spikes == cnt_t'(RELAY_ONE) || spikes == cnt_t'(RELAY_ZERO)));

endmodule

// File: rtl/spk_accum.sv
`timescale 1ns/1ps
module spk_accum
    import spk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  tok_e                  kind_in,
    input  logic [N_OPS-1:0][CNT_W-1:0] contrib,
    output logic                  sum_valid,
    output logic                  sum_bit
);

    tok_e  kind_s1;
    tok_e  kind_s2;
    logic  carry_q;
    cnt_t  count;
    fire_t rule;
    logic  valid_q;
    logic  bit_q;

    always_comb begin
        count = cnt_t'(carry_q);
        for (int i = 0; i < N_OPS; i++)
            count = count + cnt_t'(contrib[i]);
        rule = pick_rule(kind_s2, count);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_s1 <= TK_IDLE;
            kind_s2 <= TK_IDLE;
            carry_q <= 1'b0;
            valid_q <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            kind_s1 <= kind_in;
            kind_s2 <= kind_s1;
            valid_q <= rule.fire;
            bit_q   <= rule.fire & (rule.pol == POL_SPIKE);
            if (kind_s2 != TK_IDLE)
                carry_q <= rule.carry;
        end
    end

    assign sum_valid = valid_q;
    assign sum_bit   = bit_q;

    assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_PAIR) |-> (count >= cnt_t'(CNT_BASE) && count <= cnt_t'(CNT_MAX)));

    assert_carry_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_PAIR && count >= cnt_t'(CNT_BASE + 2)) |=> carry_q);

    assert_carry_none_R4: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_PAIR && count <= cnt_t'(CNT_BASE + 1)) |=> !carry_q);

    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_FLUSH) |=> !carry_q);

    assert_flush_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_FLUSH && !carry_q) |=> !sum_valid);

    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_FLUSH) |-> (count <= cnt_t'(1)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (kind_s2 == TK_IDLE) |=> !sum_valid && $stable(carry_q));

endmodule

// File: rtl/serial_spike_adder.sv
`timescale 1ns/1ps
module serial_spike_adder
    import spk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic a_valid,
    input  logic a_bit,
    input  logic b_valid,
    input  logic b_bit,
    input  logic last,
    output logic sum_valid,
    output logic sum_bit,
    output logic proto_err
);

    tok_e                       tok;
    logic [N_OPS-1:0]           op_live;
    logic [N_OPS-1:0]           op_bits;
    logic [N_OPS-1:0][CNT_W-1:0] contrib;

    spk_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .a_valid   (a_valid),
        .a_bit     (a_bit),
        .b_valid   (b_valid),
        .b_bit     (b_bit),
        .last      (last),
        .tok       (tok),
        .op_live   (op_live),
        .op_bits   (op_bits),
        .proto_err (proto_err)
    );

    for (genvar g = 0; g < N_OPS; g++) begin : g_relay
        spk_relay u_relay (
            .clk    (clk),
            .rst    (rst),
            .live   (op_live[g]),
            .bitv   (op_bits[g]),
            .spikes (contrib[g])
        );
    end

    spk_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .kind_in   (tok),
        .contrib   (contrib),
        .sum_valid (sum_valid),
        .sum_bit   (sum_bit)
    );

endmodule

// File: tb/test_serial_spike_adder.sv
`timescale 1ns/1ps
module test_serial_spike_adder;

    logic clk = 1'b0;
    logic rst, a_valid, a_bit, b_valid, b_bit, last;
    logic sum_valid, sum_bit, proto_err;

    always #2.5 clk = ~clk;

    serial_spike_adder i_serial_spike_adder (
        .clk(clk), .rst(rst), .a_valid(a_valid), .a_bit(a_bit),
        .b_valid(b_valid), .b_bit(b_bit), .last(last),
        .sum_valid(sum_valid), .sum_bit(sum_bit), .proto_err(proto_err)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;
    bit exp_b [0:511];
    bit got_b [0:511];
    int exp_n = 0;
    int got_n = 0;

    // {width, a, b}
    localparam logic [23:0] VEC [7] = '{
        {8'd4, 8'd5,   8'd3},
        {8'd4, 8'd15,  8'd1},
        {8'd8, 8'd255, 8'd255},
        {8'd3, 8'd0,   8'd0},
        {8'd1, 8'd1,   8'd1},
        {8'd5, 8'd10,  8'd5},
        {8'd8, 8'd170, 8'd85}
    };

    always @(negedge clk) begin
        if (mon_on && sum_valid) begin
            got_b[got_n] = sum_bit;
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic beat(input bit av, input bit ab, input bit bv, input bit bb, input bit l);
        @(negedge clk);
        a_valid = av; a_bit = ab; b_valid = bv; b_bit = bb; last = l;
    endtask

    task automatic idle();
        beat(0, 0, 0, 0, 0);
    endtask

    task automatic push(input bit v);
        exp_b[exp_n] = v;
        exp_n++;
    endtask

    task automatic send_word(input int w, input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        for (int i = 0; i < w; i++) begin
            beat(1, a[i], 1, b[i], i == w - 1);
            push(s[i]);
        end
        if (s[w]) push(1'b1);
        idle();
    endtask

    task automatic compare(input string req);
        for (int i = 0; i < 6; i++) idle();
        chk(got_n == exp_n, {req, " digit count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got_b[i] == exp_b[i], {req, " digit value"}, got_b[i], exp_b[i]);
        exp_n = 0;
        got_n = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        a_valid = 0; a_bit = 0; b_valid = 0; b_bit = 0; last = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        rst = 1; a_valid = 0; a_bit = 0; b_valid = 0; b_bit = 0; last = 0;
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk(sum_valid == 0, "R1 sum_valid after reset", sum_valid, 0);
        chk(proto_err == 0, "R1 proto_err after reset", proto_err, 0);

        // R6: latency of one pair (1 + 0, count 3)
        beat(1, 1, 1, 0, 1);
        idle();
        chk(sum_valid == 0, "R6 no digit after edge 1", sum_valid, 0);
        idle();
        chk(sum_valid == 0, "R6 no digit after edge 2", sum_valid, 0);
        idle();
        chk(sum_valid == 1, "R6 digit after edge 3", sum_valid, 1);
        chk(sum_bit == 1, "R4 count 3 emits spike", sum_bit, 1);
        idle();
        chk(sum_valid == 0, "R5 flush without carry is silent", sum_valid, 0);
        repeat (3) idle();

        // R2 R3 R4 R5 R9: vector table
        mon_on = 1;
        foreach (VEC[k]) begin
            send_word(int'(VEC[k][23:16]), VEC[k][15:8], VEC[k][7:0]);
        end
        compare("R3/R4/R5/R9 table");

        // R7: lone operand is flagged and leaves carry alone
        beat(1, 1, 1, 1, 0); push(0);
        beat(1, 1, 0, 0, 0);
        @(negedge clk);
        chk(proto_err == 1, "R7 lone operand flagged", proto_err, 1);
        a_valid = 1; a_bit = 0; b_valid = 1; b_bit = 0; last = 1; push(1);
        idle();
        chk(proto_err == 0, "R7 error is a single pulse", proto_err, 0);
        compare("R7 carry kept across dropped beat");

        // R8: pair inside the flush slot
        beat(1, 1, 1, 1, 1); push(0);
        beat(1, 1, 1, 1, 1);
        idle();
        chk(proto_err == 1, "R8 pair in flush slot flagged", proto_err, 1);
        push(1);
        compare("R8 dropped pair, flush still emits carry");

        // R1: reset clears a held carry
        beat(1, 1, 1, 1, 0); push(0);
        repeat (4) idle();
        do_reset();
        beat(1, 0, 1, 0, 1); push(0);
        idle();
        compare("R1 carry cleared by reset");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule